// File: doc/BRIEF.md
# Reset-Time Strap Configuration Loader

This block sits next to the management registers of a 10/100 Ethernet PHY digital core. It takes a 5-bit station address and a 3-bit configuration code from external strap inputs, which are held static by resistors or board logic. Each strap passes through a two-flop synchroniser. On the first clock after hardware reset is released, the block latches the synchronised values and decodes the code into default control and advertisement bits. The latched address goes to the management frame decoder for address matching and to the transmit scrambler as its seed. After this capture the strap pins are no longer observed.

A small register port gives read and write access to three registers:
- **Control** (index 0): bit 15 soft reset, bit 13 speed (1 = 100 Mb/s), bit 12 auto-negotiation enable, bit 11 power-down (read-only), bit 8 full duplex.
- **Advertisement** (index 4): bits 8:5 are the abilities; bits 4:0 read 00001.
- **Config** (index 18): bits 7:5 hold the stored configuration code; bits 4:0 show the latched address (read-only).

Writing 1 to control bit 15 starts a soft reset. A soft reset reloads the defaults from the stored code in bits 7:5 and ignores the pins. Code 110 parks the core in power-down. The only way out is to write a different code into bits 7:5 and then issue a soft reset.

The sequencer has four states:
- **ST_HWLOAD**: entered while hardware reset is asserted. It captures the straps and loads their defaults, then moves to ST_RUN unconditionally.
- **ST_RUN**: accepts register writes. A write with bit 15 set to control moves it to ST_SOFTLOAD.
- **ST_SOFTLOAD**: reloads the defaults from the stored code, then moves to ST_CLEAR.
- **ST_CLEAR**: clears bit 15 and returns to ST_RUN.

Top module: `strap_cfg_loader`

## Requirements
- R1: The address is captured on the first clock edge with reset released, from the pin value present two edges earlier. It never changes afterwards until the next hardware reset.
- R2: The latched address drives `phy_addr_o` and reads back in config register bits 4:0. The code used at hardware load reads back in config bits 7:5.
- R3: Codes 000, 001, 010 and 011 load control {13,12,8} = {0,0,0}, {0,0,1}, {1,0,0} and {1,0,1} respectively. They leave advertisement bits 8:5 at their current value.
- R4: Codes 100 and 101 load control {13,12,8} = {1,1,0} and advertisement bits 8:5 = 0100. Only code 101 drives `repeater_o` to 1.
- R5: `crs_on_tx_o` is 1 after a load with code 000, 010 or 100, and 0 after any other code.
- R6: Code 111 loads control {13,12,8} = {1,1,1} and advertisement bits 8:5 = 1111.
- R7: Code 110 sets control bit 11 and `power_down_o`, with all other control defaults 0. Register writes cannot change bit 11.
- R8: Writing 1 to control bit 15 reloads the defaults from config bits 7:5 and ignores the pins. Bit 15 reads 1 for two cycles and then 0.
- R9: Writes that arrive while a soft reset is in progress have no effect.
- R10: Writing config bits 7:5 changes no output and no default until the next soft reset.
- R11: During hardware reset the control register reads 0x0000, advertisement reads 0x01E1, config reads 0x0000, and all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Hardware reset, active low, asynchronous |
| strap_addr_i | input | 5 | Address strap pins |
| strap_mode_i | input | 3 | Configuration code strap pins |
| acc_addr_i | input | 5 | Register index for read and write |
| acc_wr_i | input | 1 | Write strobe |
| acc_wdata_i | input | 16 | Write data |
| acc_rdata_o | output | 16 | Read data of the indexed register (combinational) |
| phy_addr_o | output | 5 | Latched address for frame match and scrambler seed |
| power_down_o | output | 1 | Core held in power-down |
| repeater_o | output | 1 | Repeater behaviour selected |
| crs_on_tx_o | output | 1 | Carrier sense also asserted during transmit |

## Verification
The assertions check on every cycle the properties that hold at all times:
- The address, power-down and datapath selections stay stable except on a load cycle.
- The soft-reset sequence always runs SOFTLOAD, then CLEAR, then RUN.
- A soft load takes power-down from the stored code, not from the pins.
- At most one sequencer action is active in any cycle.

Only the bench's scenarios can show the rest:
- Each of the eight codes decodes to its exact register values.
- The advertisement bits are left untouched by codes 000 to 011.
- Pins changed after release are ignored, and a write during a reload is discarded.
- Power-down can only be left by rewriting the code and then issuing a soft reset.

// File: rtl/strap_cfg_pkg.sv
package strap_cfg_pkg;

    typedef enum logic [1:0] {
        ST_HWLOAD   = 2'd0,
        ST_RUN      = 2'd1,
        ST_SOFTLOAD = 2'd2,
        ST_CLEAR    = 2'd3
    } ld_state_t;

    typedef struct packed {
        logic       spd;
        logic       ane;
        logic       dup;
        logic       pd;
        logic       adv_set;
        logic [3:0] adv;
        logic       rpt;
        logic       crs_tx;
    } dflt_t;

    function automatic dflt_t decode_mode(input logic [2:0] m);
        dflt_t d;
        d = '0;
        unique case (m)
            3'b000: begin d.crs_tx = 1'b1; end
            3'b001: begin d.dup = 1'b1; end
            3'b010: begin d.spd = 1'b1; d.crs_tx = 1'b1; end
            3'b011: begin d.spd = 1'b1; d.dup = 1'b1; end
            3'b100: begin
                d.spd = 1'b1; d.ane = 1'b1; d.adv_set = 1'b1;
                d.adv = 4'b0100; d.crs_tx = 1'b1;
            end
            3'b101: begin
                d.spd = 1'b1; d.ane = 1'b1; d.adv_set = 1'b1;
                d.adv = 4'b0100; d.rpt = 1'b1;
            end
            3'b110: begin d.pd = 1'b1; end
            3'b111: begin
                d.spd = 1'b1; d.ane = 1'b1; d.dup = 1'b1;
                d.adv_set = 1'b1; d.adv = 4'b1111;
            end
        endcase
        return d;
    endfunction

endpackage

// File: rtl/strap_sync.sv
module strap_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] stage_q [STAGES];

    always_ff @(posedge clk) begin
        stage_q[0] <= d_i;
    end

    generate
        for (genvar s = 1; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk) begin
                stage_q[s] <= stage_q[s-1];
            end
        end
    endgenerate

    assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/load_fsm.sv
module load_fsm
    import strap_cfg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic soft_req,
    output logic load_hw,
    output logic load_soft,
    output logic clear_sr,
    output logic wr_allow
);
    ld_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_HWLOAD;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d   = state_q;
        load_hw   = 1'b0;
        load_soft = 1'b0;
        clear_sr  = 1'b0;
        wr_allow  = 1'b0;
        unique case (state_q)
            ST_HWLOAD: begin
                load_hw = 1'b1;
                state_d = ST_RUN;
            end
            ST_RUN: begin
                wr_allow = 1'b1;
                if (soft_req) state_d = ST_SOFTLOAD;
            end
            ST_SOFTLOAD: begin
                load_soft = 1'b1;
                state_d   = ST_CLEAR;
            end
            ST_CLEAR: begin
                clear_sr = 1'b1;
                state_d  = ST_RUN;
            end
        endcase
    end

    // R8: the soft-reset sequence always runs SOFTLOAD -> CLEAR -> RUN
    a_r8_soft_sequence: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SOFTLOAD) |=> (state_q == ST_CLEAR) ##1 (state_q == ST_RUN));

    // R9: at most one sequencer action is active in any cycle
    a_r9_one_action: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({load_hw, load_soft, clear_sr, wr_allow}));
endmodule

// File: rtl/cfg_regs.sv
module cfg_regs
    import strap_cfg_pkg::*;
#(
    parameter int AW       = 5,
    parameter int MW       = 3,
    parameter int IDX_W    = 5,
    parameter int DW       = 16,
    parameter int CTL_IDX  = 0,
    parameter int ADV_IDX  = 4,
    parameter int CFG_IDX  = 18
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_hw,
    input  logic             load_soft,
    input  logic             clear_sr,
    input  logic             wr_allow,
    input  logic [AW-1:0]    strap_addr,
    input  logic [MW-1:0]    strap_mode,
    input  logic [IDX_W-1:0] acc_addr,
    input  logic             acc_wr,
    input  logic [DW-1:0]    acc_wdata,
    output logic [DW-1:0]    acc_rdata,
    output logic             soft_req,
    output logic [AW-1:0]    phy_addr,
    output logic             power_down,
    output logic             repeater,
    output logic             crs_on_tx
);
    localparam int SR_BIT  = 15;
    localparam int SPD_BIT = 13;
    localparam int ANE_BIT = 12;
    localparam int PD_BIT  = 11;
    localparam int DUP_BIT = 8;
    localparam int ADV_LO  = 5;
    localparam int MODE_LO = 5;
    localparam logic [DW-1:0] CTL_WMASK = (DW'(1) << SPD_BIT) | (DW'(1) << ANE_BIT)
                                        | (DW'(1) << DUP_BIT);
    localparam logic [DW-1:0] ADV_WMASK = DW'(4'hF) << ADV_LO;
    localparam logic [DW-1:0] CFG_WMASK = DW'((1 << MW) - 1) << MODE_LO;
    localparam logic [DW-1:0] ADV_RST   = ADV_WMASK | DW'(1);

    logic [DW-1:0] ctl_q, adv_q, cfg_q;
    logic [AW-1:0] addr_q;
    logic          rpt_q, crs_q;
    logic [MW-1:0] src_mode;
    dflt_t         dflt;

    always_comb begin
        src_mode = load_hw ? strap_mode : cfg_q[MODE_LO +: MW];
        dflt     = decode_mode(src_mode);
        soft_req = wr_allow && acc_wr && (acc_addr == IDX_W'(CTL_IDX)) && acc_wdata[SR_BIT];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q  <= '0;
            adv_q  <= ADV_RST;
            cfg_q  <= '0;
            addr_q <= '0;
            rpt_q  <= 1'b0;
            crs_q  <= 1'b0;
        end else if (load_hw || load_soft) begin
            ctl_q          <= '0;
            ctl_q[SR_BIT]  <= load_soft;
            ctl_q[SPD_BIT] <= dflt.spd;
            ctl_q[ANE_BIT] <= dflt.ane;
            ctl_q[PD_BIT]  <= dflt.pd;
            ctl_q[DUP_BIT] <= dflt.dup;
            if (dflt.adv_set) adv_q[ADV_LO +: 4] <= dflt.adv;
            rpt_q <= dflt.rpt;
            crs_q <= dflt.crs_tx;
            if (load_hw) begin
                cfg_q[MODE_LO +: MW] <= strap_mode;
                addr_q               <= strap_addr;
            end
        end else if (clear_sr) begin
            ctl_q[SR_BIT] <= 1'b0;
        end else if (soft_req) begin
            ctl_q[SR_BIT] <= 1'b1;
        end else if (wr_allow && acc_wr) begin
            if (acc_addr == IDX_W'(CTL_IDX))
                ctl_q <= (ctl_q & ~CTL_WMASK) | (acc_wdata & CTL_WMASK);
            else if (acc_addr == IDX_W'(ADV_IDX))
                adv_q <= (adv_q & ~ADV_WMASK) | (acc_wdata & ADV_WMASK);
            else if (acc_addr == IDX_W'(CFG_IDX))
                cfg_q <= (cfg_q & ~CFG_WMASK) | (acc_wdata & CFG_WMASK);
        end
    end

    always_comb begin
        if (acc_addr == IDX_W'(CTL_IDX))      acc_rdata = ctl_q;
        else if (acc_addr == IDX_W'(ADV_IDX)) acc_rdata = adv_q;
        else if (acc_addr == IDX_W'(CFG_IDX)) acc_rdata = cfg_q | DW'(addr_q);
        else                                  acc_rdata = '0;
    end

    assign phy_addr   = addr_q;
    assign power_down = ctl_q[PD_BIT];
    assign repeater   = rpt_q;
    assign crs_on_tx  = crs_q;

    // R1: the address only changes on the hardware load cycle
    a_r1_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !load_hw |=> $stable(phy_addr));

    // R7: power-down only changes on a load cycle, never through a write
    a_r7_pd_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(load_hw || load_soft) |=> $stable(power_down));

    // R8: a soft load takes power-down from the stored code, not the pins
    a_r8_soft_from_field: assert property (@(posedge clk) disable iff (!rst_n)
        load_soft |=> (power_down == ($past(cfg_q[MODE_LO +: MW]) == MW'(3'b110))));

    // R10: datapath selections hold between loads
    a_r10_sel_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(load_hw || load_soft) |=> $stable({repeater, crs_on_tx}));
endmodule

// File: rtl/strap_cfg_loader.sv
module strap_cfg_loader #(
    parameter int AW     = 5,
    parameter int MW     = 3,
    parameter int IDX_W  = 5,
    parameter int DW     = 16,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [AW-1:0]    strap_addr_i,
    input  logic [MW-1:0]    strap_mode_i,
    input  logic [IDX_W-1:0] acc_addr_i,
    input  logic             acc_wr_i,
    input  logic [DW-1:0]    acc_wdata_i,
    output logic [DW-1:0]    acc_rdata_o,
    output logic [AW-1:0]    phy_addr_o,
    output logic             power_down_o,
    output logic             repeater_o,
    output logic             crs_on_tx_o
);
    localparam int SW = AW + MW;

    logic [SW-1:0] strap_sync_q;
    logic          load_hw, load_soft, clear_sr, wr_allow, soft_req;

    strap_sync #(.W(SW), .STAGES(STAGES)) u_sync (
        .clk (clk),
        .d_i ({strap_addr_i, strap_mode_i}),
        .q_o (strap_sync_q)
    );

    load_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .soft_req  (soft_req),
        .load_hw   (load_hw),
        .load_soft (load_soft),
        .clear_sr  (clear_sr),
        .wr_allow  (wr_allow)
    );

    cfg_regs #(.AW(AW), .MW(MW), .IDX_W(IDX_W), .DW(DW)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_hw    (load_hw),
        .load_soft  (load_soft),
        .clear_sr   (clear_sr),
        .wr_allow   (wr_allow),
        .strap_addr (strap_sync_q[SW-1 -: AW]),
        .strap_mode (strap_sync_q[MW-1:0]),
        .acc_addr   (acc_addr_i),
        .acc_wr     (acc_wr_i),
        .acc_wdata  (acc_wdata_i),
        .acc_rdata  (acc_rdata_o),
        .soft_req   (soft_req),
        .phy_addr   (phy_addr_o),
        .power_down (power_down_o),
        .repeater   (repeater_o),
        .crs_on_tx  (crs_on_tx_o)
    );
endmodule

// File: tb/test_strap_cfg_loader.sv
module test_strap_cfg_loader;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  pin_a = 5'h00;
    logic [2:0]  pin_m = 3'b000;
    logic [4:0]  acc_addr = 5'd0;
    logic        acc_wr = 1'b0;
    logic [15:0] acc_wdata = 16'h0000;
    logic [15:0] acc_rdata;
    logic [4:0]  phy_addr;
    logic        power_down, repeater, crs_on_tx;

    int checks = 0;
    int errs   = 0;
    int cycles = 0;
    bit started = 0;

    strap_cfg_loader i_strap_cfg_loader (
        .clk(clk), .rst_n(rst_n), .strap_addr_i(pin_a), .strap_mode_i(pin_m),
        .acc_addr_i(acc_addr), .acc_wr_i(acc_wr), .acc_wdata_i(acc_wdata),
        .acc_rdata_o(acc_rdata), .phy_addr_o(phy_addr), .power_down_o(power_down),
        .repeater_o(repeater), .crs_on_tx_o(crs_on_tx)
    );

    always #(CLK_P/2) clk = ~clk;

    // behavioural reference model
    int         m_st = 0;
    bit         m_sr = 0, m_spd = 0, m_ane = 0, m_dup = 0, m_pd = 0, m_rpt = 0, m_crs = 0;
    bit [3:0]   m_adv = 4'hF;
    bit [2:0]   m_field = 0;
    bit [4:0]   m_addr = 0;
    bit [4:0]   h1_a = 0, h2_a = 0;
    bit [2:0]   h1_m = 0, h2_m = 0;

    task automatic m_load(input bit [2:0] code);
        m_spd = (code >= 2 && code != 6);
        m_ane = (code >= 4 && code != 6);
        m_dup = (code == 1 || code == 3 || code == 7);
        m_pd  = (code == 6);
        m_rpt = (code == 5);
        m_crs = (code == 0 || code == 2 || code == 4);
        if (code == 4 || code == 5) m_adv = 4'b0100;
        if (code == 7)              m_adv = 4'b1111;
    endtask

    always @(posedge clk) begin
        cycles++;
        started = 1;
        if (!rst_n) begin
            m_st = 0; m_sr = 0; m_spd = 0; m_ane = 0; m_dup = 0; m_pd = 0;
            m_rpt = 0; m_crs = 0; m_adv = 4'hF; m_field = 0; m_addr = 0;
        end else begin
            case (m_st)
                0: begin
                    m_addr = h2_a; m_field = h2_m; m_sr = 0;
                    m_load(h2_m); m_st = 1;
                end
                1: if (acc_wr) begin
                    if (acc_addr == 0 && acc_wdata[15]) begin m_sr = 1; m_st = 2; end
                    else if (acc_addr == 0) begin
                        m_spd = acc_wdata[13]; m_ane = acc_wdata[12]; m_dup = acc_wdata[8];
                    end
                    else if (acc_addr == 4)  m_adv = acc_wdata[8:5];
                    else if (acc_addr == 18) m_field = acc_wdata[7:5];
                end
                2: begin m_load(m_field); m_st = 3; end
                default: begin m_sr = 0; m_st = 1; end
            endcase
        end
        h2_a = h1_a; h2_m = h1_m; h1_a = pin_a; h1_m = pin_m;
    end

    function automatic bit [15:0] m_rd(input bit [4:0] a);
        case (a)
            5'd0:  return {m_sr, 1'b0, m_spd, m_ane, m_pd, 2'b00, m_dup, 8'h00};
            5'd4:  return {7'h00, m_adv, 5'b00001};
            5'd18: return {8'h00, m_field, m_addr};
            default: return 16'h0000;
        endcase
    endfunction

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // every-cycle comparison against the model
    always @(negedge clk) begin
        if (started) begin
            chk("R1 phy_addr", 16'(phy_addr), 16'(m_addr));
            chk("R7 power_down", 16'(power_down), 16'(m_pd));
            chk("R4 repeater", 16'(repeater), 16'(m_rpt));
            chk("R5 crs_on_tx", 16'(crs_on_tx), 16'(m_crs));
            chk(acc_addr == 0 ? "R8 ctl read" : acc_addr == 4 ? "R3 adv read" : "R10 cfg read",
                acc_rdata, m_rd(acc_addr));
        end
    end

    always @(posedge clk) begin
        if (cycles > 100000) begin
            errs++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errs);
            $finish;
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic hw_reset(input logic [4:0] a, input logic [2:0] m);
        @(negedge clk); #1 rst_n = 1'b0; pin_a = a; pin_m = m;
        idle(4);
        #1 rst_n = 1'b1;
        idle(3);
    endtask

    task automatic wr(input logic [4:0] a, input logic [15:0] d);
        @(negedge clk); #1 acc_addr = a; acc_wdata = d; acc_wr = 1'b1;
        @(negedge clk); #1 acc_wr = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, input logic [15:0] exp, input string tag);
        @(negedge clk); #1 acc_addr = a;
        @(negedge clk); chk(tag, acc_rdata, exp);
    endtask

    initial begin
        // R11 reset state
        idle(3);
        chk("R11 addr in reset", 16'(phy_addr), 16'h0000);
        rd(5'd4, 16'h01E1, "R11 adv reset");
        rd(5'd0, 16'h0000, "R11 ctl reset");
        rd(5'd18, 16'h0000, "R11 cfg reset");

        hw_reset(5'h0A, 3'b100);
        chk("R2 phy_addr", 16'(phy_addr), 16'h000A);
        rd(5'd0, 16'h3000, "R4 ctl code 100");
        rd(5'd4, 16'h0081, "R4 adv code 100");
        rd(5'd18, 16'h008A, "R2 cfg readback");
        chk("R5 crs code 100", 16'(crs_on_tx), 16'h0001);

        // R1 pins ignored after capture
        pin_a = 5'h1F; pin_m = 3'b111;
        idle(5);
        chk("R1 addr held", 16'(phy_addr), 16'h000A);

        // R8 soft reset uses stored code, bit 15 visible then clear
        acc_addr = 5'd0;
        wr(5'd0, 16'h8000);
        chk("R8 bit15 set", acc_rdata & 16'h8000, 16'h8000);
        idle(3);
        rd(5'd0, 16'h3000, "R8 soft from field");

        // R3 adv untouched by code 011 on soft reload
        wr(5'd18, 16'h0060);
        wr(5'd0, 16'h8000);
        idle(3);
        rd(5'd0, 16'h2100, "R3 soft code 011");
        rd(5'd4, 16'h0081, "R3 adv unchanged");

        // R10 field write has no effect until soft reset
        wr(5'd18, 16'h00C0);
        idle(2);
        chk("R10 pd unchanged", 16'(power_down), 16'h0000);
        rd(5'd0, 16'h2100, "R10 ctl unchanged");
        wr(5'd0, 16'h8000);
        idle(3);
        chk("R7 pd after soft", 16'(power_down), 16'h0001);
        rd(5'd0, 16'h0800, "R7 ctl code 110");
        wr(5'd0, 16'h0000);
        rd(5'd0, 16'h0800, "R7 pd not writable");

        // R6 exit power-down via code 111 + soft reset
        wr(5'd18, 16'h00E0);
        wr(5'd0, 16'h8000);
        idle(3);
        rd(5'd0, 16'h3100, "R6 ctl code 111");
        rd(5'd4, 16'h01E1, "R6 adv code 111");

        // R9 write during soft reload ignored
        wr(5'd0, 16'h8000);
        wr(5'd0, 16'h0000);
        idle(2);
        rd(5'd0, 16'h3100, "R9 write ignored");

        // R3 / R4 / R5 hardware codes
        hw_reset(5'h03, 3'b000);
        rd(5'd0, 16'h0000, "R3 code 000");
        chk("R5 crs code 000", 16'(crs_on_tx), 16'h0001);
        hw_reset(5'h04, 3'b001);
        rd(5'd0, 16'h0100, "R3 code 001");
        chk("R5 crs code 001", 16'(crs_on_tx), 16'h0000);
        hw_reset(5'h05, 3'b010);
        rd(5'd0, 16'h2000, "R3 code 010");
        hw_reset(5'h06, 3'b011);
        rd(5'd0, 16'h2100, "R3 code 011");
        rd(5'd4, 16'h01E1, "R3 adv default kept");
        hw_reset(5'h11, 3'b101);
        rd(5'd0, 16'h3000, "R4 code 101");
        chk("R4 repeater code 101", 16'(repeater), 16'h0001);
        chk("R5 crs code 101", 16'(crs_on_tx), 16'h0000);
        hw_reset(5'h12, 3'b110);
        chk("R7 pd from pins", 16'(power_down), 16'h0001);

        idle(2);
        $display("  CHECKS %0d ERRORS %0d", checks, errs);
        $finish;
    end
endmodule